// File: doc/BRIEF.md
# Saturating Doubling Widening Multiply-Accumulate by Broadcast Element

This block computes one 128-bit segment of a vector multiply-accumulate that widens its result. A 32-bit instruction word picks one of two element sizes and an element index. The accumulator lanes are twice as wide as the narrow source elements. Each accumulator lane takes the even-numbered narrow element of the first source lying under it. That element is multiplied by a single narrow element of the second source, and the index chooses which element, so the same value is used by every lane. The product is doubled and clamped to the signed range of the wide lane. The clamped product is then added to the existing accumulator lane and the sum is clamped again.

A small decoder checks the fixed opcode bits of the instruction word, extracts the size and the index, and flags words that match neither layout. An illegal word returns the accumulator unchanged. Results are registered once. A two-state output stage governs `out_valid`:
- `ST_EMPTY`: no result is held.
- `ST_FULL`: a result is held.
- `GO_LOAD`: an accepted input moves `ST_EMPTY` to `ST_FULL`.
- `GO_REFILL`: an accepted input keeps the stage in `ST_FULL`.
- `GO_DRAIN`: a cycle with no input returns the stage to `ST_EMPTY`.

A sticky flag records any clamping in either stage until software-side logic clears it with `sat_clr`.

Top module: `sdmac_seg`

## Requirements
- R1: A word is legal only when all of the following hold: bits 31:24 are 0x44, bit 21 is 1, bits 15:12 are 0010 and bit 10 is 0. Bits 23:22 must also be 10 (16-bit sources, 32-bit lanes) or 11 (32-bit sources, 64-bit lanes). Any other word sets `out_illegal`, returns `acc_in` unchanged on `acc_out` and leaves the sticky flag untouched.
- R2: For 16-bit sources the index is {bit20, bit19, bit11}, in the range 0 to 7. For 32-bit sources it is {bit20, bit11}, in the range 0 to 3. The multiplier is the `src_b` element at bits [index*N +: N], and every lane uses it.
- R3: Accumulator lane e occupies `acc_in`/`acc_out` bits [e*2N +: 2N] and uses the `src_a` element at bits [2e*N +: N].
- R4: The signed product is doubled and clamped to the 2N-bit signed range. This clamp occurs only when both operands are the most negative N-bit value, and it yields the largest positive 2N-bit value.
- R5: The clamped product is added to the signed accumulator lane. A sum above the 2N-bit range gives the maximum value and a sum below it gives the minimum value.
- R6: `out_valid` rises one cycle after `in_valid` and falls after a cycle with no input. Synchronous reset clears `out_valid` and `sat_sticky`.
- R7: `sat_sticky` is set when a legal accepted operation clamps in any lane at either stage. It stays set until `sat_clr` is asserted. A clamp accepted in the same cycle as `sat_clr` leaves the flag set.
- R8: The odd-numbered narrow elements of `src_a` have no effect on `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | operands and instruction are valid this cycle |
| insn | input | 32 | instruction word |
| src_a | input | 128 | first source segment |
| src_b | input | 128 | second source segment |
| acc_in | input | 128 | accumulator segment |
| sat_clr | input | 1 | synchronous clear of the sticky flag |
| out_valid | output | 1 | result valid |
| acc_out | output | 128 | updated accumulator segment |
| out_illegal | output | 1 | held result came from an illegal word |
| sat_sticky | output | 1 | sticky saturation flag |

## Verification
The arithmetic is tried with pseudo-random operands for every index of both sizes. This shows that the right broadcast element and the right even lanes are used. Directed cases use the most negative value times itself to separate the product clamp from the accumulate clamp. Sums pushed past the top and past the bottom of the range show that the clamp follows the direction of overflow. Operand pairs that differ only in odd elements, malformed opcodes, and clear pulses with and without a concurrent clamp check the ignore and sticky rules.

// File: rtl/sdmac_pkg.sv
package sdmac_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    typedef enum logic [1:0] {
        SZ_HALF = 2'b10,
        SZ_WORD = 2'b11
    } size_e;

    localparam logic [7:0] OPC_TOP = 8'h44;
    localparam logic [3:0] OPC_MID = 4'b0010;
endpackage

// File: rtl/sdmac_decode.sv
module sdmac_decode
    import sdmac_pkg::*;
(
    input  logic [31:0] insn,
    output logic        legal,
    output logic        is_word,
    output logic [2:0]  idx
);
    logic unused_bits;
    logic fixed_ok;
    logic size_ok;

    assign unused_bits = ^insn;

    always_comb begin
        fixed_ok = (insn[31:24] == OPC_TOP) && insn[21] &&
                   (insn[15:12] == OPC_MID) && !insn[10];
        size_ok  = (insn[23:22] == SZ_HALF) || (insn[23:22] == SZ_WORD);
        legal    = fixed_ok && size_ok;
        is_word  = (insn[23:22] == SZ_WORD);
        if (is_word)
            idx = {1'b0, insn[20], insn[11]};
        else
            idx = {insn[20:19], insn[11]};
        if (legal && is_word)
            assert_word_index_R2: assert (idx[2] == 1'b0)
                else $error("word index out of range");
    end
endmodule

// File: rtl/sdmac_lane.sv
module sdmac_lane #(
    parameter int NW = 16
) (
    input  logic signed [NW-1:0]   op_a,
    input  logic signed [NW-1:0]   op_b,
    input  logic signed [2*NW-1:0] acc,
    output logic signed [2*NW-1:0] res,
    output logic                   prod_clamp,
    output logic                   sum_clamp
);
    localparam int DW = 2 * NW;
    localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [NW-1:0] NMIN = {1'b1, {(NW-1){1'b0}}};

    logic signed [DW-1:0] prod;
    logic        [DW:0]   dbl;
    logic        [DW-1:0] psat;
    logic        [DW:0]   sum;

    always_comb begin
        prod       = op_a * op_b;
        dbl        = {prod, 1'b0};
        prod_clamp = dbl[DW] ^ dbl[DW-1];
        psat       = prod_clamp ? DMAX : dbl[DW-1:0];
        sum        = {psat[DW-1], psat} + {acc[DW-1], acc};
        sum_clamp  = sum[DW] ^ sum[DW-1];
        if (sum_clamp)
            res = sum[DW] ? DMIN : DMAX;
        else
            res = sum[DW-1:0];
        if (prod_clamp)
            assert_prod_clamp_R4: assert (op_a == NMIN && op_b == NMIN)
                else $error("product clamp without double minimum");
        if (sum_clamp)
            assert_sum_clamp_R5: assert (res == DMIN || res == DMAX)
                else $error("sum clamp gave non-extreme value");
    end
endmodule

// File: rtl/sdmac_seg.sv
module sdmac_seg
    import sdmac_pkg::*;
#(
    parameter int SEG_W = 128,
    parameter int HN    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [SEG_W-1:0] src_a,
    input  logic [SEG_W-1:0] src_b,
    input  logic [SEG_W-1:0] acc_in,
    input  logic             sat_clr,
    output logic             out_valid,
    output logic [SEG_W-1:0] acc_out,
    output logic             out_illegal,
    output logic             sat_sticky
);
    localparam int WN = 2 * HN;
    localparam int HL = SEG_W / (2 * HN);
    localparam int WL = SEG_W / (2 * WN);

    logic             dec_legal;
    logic             dec_word;
    logic [2:0]       dec_idx;
    logic [HN-1:0]    b_half;
    logic [WN-1:0]    b_word;
    logic [SEG_W-1:0] res_half;
    logic [SEG_W-1:0] res_word;
    logic [HL-1:0]    pc_h, sc_h;
    logic [WL-1:0]    pc_w, sc_w;
    logic             sat_any;
    logic [SEG_W-1:0] nxt_acc;
    logic             unused_odd;

    stage_e st, st_nxt;
    logic [SEG_W-1:0] acc_q;
    logic             ill_q;
    logic             sticky_q;

    assign unused_odd = ^src_a;

    sdmac_decode u_dec (
        .insn    (insn),
        .legal   (dec_legal),
        .is_word (dec_word),
        .idx     (dec_idx)
    );

    assign b_half = src_b[dec_idx*HN +: HN];
    assign b_word = src_b[dec_idx[1:0]*WN +: WN];

    for (genvar e = 0; e < HL; e++) begin : g_half
        sdmac_lane #(.NW(HN)) u_lane (
            .op_a       (src_a[2*e*HN +: HN]),
            .op_b       (b_half),
            .acc        (acc_in[e*WN +: WN]),
            .res        (res_half[e*WN +: WN]),
            .prod_clamp (pc_h[e]),
            .sum_clamp  (sc_h[e])
        );
    end

    for (genvar e = 0; e < WL; e++) begin : g_word
        sdmac_lane #(.NW(WN)) u_lane (
            .op_a       (src_a[2*e*WN +: WN]),
            .op_b       (b_word),
            .acc        (acc_in[e*2*WN +: 2*WN]),
            .res        (res_word[e*2*WN +: 2*WN]),
            .prod_clamp (pc_w[e]),
            .sum_clamp  (sc_w[e])
        );
    end

    always_comb begin
        if (!dec_legal)
            nxt_acc = acc_in;
        else if (dec_word)
            nxt_acc = res_word;
        else
            nxt_acc = res_half;
        sat_any = dec_legal && (dec_word ? (|{pc_w, sc_w}) : (|{pc_h, sc_h}));
    end

    always_comb begin
        unique case (st)
            ST_EMPTY: st_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  st_nxt = in_valid ? ST_FULL : ST_EMPTY;
            default:  st_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_EMPTY;
        else
            st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            ill_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            if (in_valid) begin
                acc_q <= nxt_acc;
                ill_q <= !dec_legal;
            end
            sticky_q <= (sticky_q && !sat_clr) || (in_valid && sat_any);
        end
    end

    always_comb begin
        out_valid   = (st == ST_FULL);
        acc_out     = acc_q;
        out_illegal = ill_q;
        sat_sticky  = sticky_q;
    end

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("out_valid did not follow input");
    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("out_valid stayed high");
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        sat_sticky && !sat_clr |=> sat_sticky) else $error("sticky lost");
    assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sat_clr && !in_valid |=> !sat_sticky) else $error("sticky not cleared");
    assert_illegal_pass_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && !dec_legal |=> out_illegal && acc_out == $past(acc_in))
        else $error("illegal word changed accumulator");
endmodule

// File: tb/sdmac_seg_test.sv
`timescale 1ns/1ps
module sdmac_seg_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
    logic         sat_clr = 1'b0;
    logic         out_valid, out_illegal, sat_sticky;
    logic [127:0] acc_out;

    int total = 0;
    int bad = 0;
    bit exp_stk = 1'b0;
    bit finished = 1'b0;

    logic [127:0] q_res[$];
    bit           q_ill[$];
    bit           q_stk[$];
    string        q_tag[$];

    always #4 clk = ~clk;

    sdmac_seg uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .sat_clr(sat_clr),
        .out_valid(out_valid), .acc_out(acc_out),
        .out_illegal(out_illegal), .sat_sticky(sat_sticky)
    );

    function automatic logic [31:0] mk(input bit word, input int idx);
        logic [31:0] w;
        w = 32'h4420_2000 | 32'h0001_02A5;
        if (word) begin
            w[23:22] = 2'b11;
            w[20] = idx[1];
            w[11] = idx[0];
        end else begin
            w[23:22] = 2'b10;
            w[20:19] = idx[2:1];
            w[11] = idx[0];
            w[18:16] = 3'b011;
        end
        return w;
    endfunction

    function automatic void model(input logic [31:0] w, input logic [127:0] a,
                                  input logic [127:0] b, input logic [127:0] c,
                                  output logic [127:0] res, output bit sat,
                                  output bit ill);
        bit word, legal;
        int n, idx, lanes;
        logic signed [71:0] x, y, z, p, s, mx, mn;
        logic [127:0] ta, tb, tc;
        logic [63:0] m64;
        word  = (w[23:22] == 2'b11);
        legal = (w[31:24] == 8'h44) && w[21] && (w[15:12] == 4'b0010) && !w[10]
                && (w[23] == 1'b1);
        ill = !legal;
        sat = 1'b0;
        res = c;
        if (!legal) return;
        n     = word ? 32 : 16;
        idx   = word ? {w[20], w[11]} : {w[20:19], w[11]};
        lanes = 128 / (2 * n);
        mx    = (72'sd1 <<< (2 * n - 1)) - 72'sd1;
        mn    = -mx - 72'sd1;
        m64   = word ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        tb    = b >> (idx * n);
        y     = word ? 72'($signed(tb[31:0])) : 72'($signed(tb[15:0]));
        res   = '0;
        for (int e = 0; e < lanes; e++) begin
            ta = a >> (2 * e * n);
            tc = c >> (2 * e * n);
            x  = word ? 72'($signed(ta[31:0])) : 72'($signed(ta[15:0]));
            z  = word ? 72'($signed(tc[63:0])) : 72'($signed(tc[31:0]));
            p  = 72'sd2 * x * y;
            if (p > mx) begin p = mx; sat = 1'b1; end
            s = z + p;
            if (s > mx) begin s = mx; sat = 1'b1; end
            if (s < mn) begin s = mn; sat = 1'b1; end
            res = res | (128'(s[63:0] & m64) << (2 * e * n));
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic op(input logic [31:0] w, input logic [127:0] a,
                      input logic [127:0] b, input logic [127:0] c,
                      input bit clr, input string tag);
        logic [127:0] r;
        bit s, il;
        insn = w; src_a = a; src_b = b; acc_in = c;
        in_valid = 1'b1; sat_clr = clr;
        model(w, a, b, c, r, s, il);
        @(posedge clk);
        exp_stk = (clr ? 1'b0 : exp_stk) | s;
        q_res.push_back(r); q_ill.push_back(il);
        q_stk.push_back(exp_stk); q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; sat_clr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_only();
        sat_clr = 1'b1; in_valid = 1'b0;
        @(posedge clk);
        exp_stk = 1'b0;
        @(negedge clk);
        sat_clr = 1'b0;
        check(sat_sticky == exp_stk, "R7", "clear", 128'(sat_sticky), 128'(exp_stk));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q_res.size() == 0) begin
                    check(1'b0, "R6", "unexpected out_valid", 128'(out_valid), 128'd0);
                end else begin
                    logic [127:0] r;
                    string t;
                    bit il, sk;
                    r = q_res.pop_front(); il = q_ill.pop_front();
                    sk = q_stk.pop_front(); t = q_tag.pop_front();
                    check(acc_out == r, t, "acc_out", acc_out, r);
                    check(out_illegal == il, t, "illegal", 128'(out_illegal), 128'(il));
                    check(sat_sticky == sk, t, "sticky", 128'(sat_sticky), 128'(sk));
                end
            end else if (q_res.size() != 0) begin
                check(1'b0, "R6", "missing out_valid", 128'(out_valid), 128'd1);
                void'(q_res.pop_front()); void'(q_ill.pop_front());
                void'(q_stk.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, c, a2;
        void'($urandom(17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "reset out_valid", 128'(out_valid), 128'd0);
        check(sat_sticky == 1'b0, "R6", "reset sticky", 128'(sat_sticky), 128'd0);

        // R2 R3: every index, small operands, both sizes
        for (int i = 0; i < 8; i++) begin
            a = {$urandom, $urandom, $urandom, $urandom} & {8{16'h0FFF}};
            b = {$urandom, $urandom, $urandom, $urandom} & {8{16'h0FFF}};
            c = {$urandom, $urandom, $urandom, $urandom} & {4{32'h0FFF_FFFF}};
            op(mk(1'b0, i), a, b, c, 1'b0, "R2_R3_half");
        end
        for (int i = 0; i < 4; i++) begin
            a = {$urandom, $urandom, $urandom, $urandom} & {4{32'h0FFF_FFFF}};
            b = {$urandom, $urandom, $urandom, $urandom} ^ {4{32'h8000_0001}};
            c = {$urandom, $urandom, $urandom, $urandom} & {2{64'h0FFF_FFFF_FFFF_FFFF}};
            op(mk(1'b1, i), a, b, c, 1'b0, "R2_R3_word");
        end
        idle(2);
        check(sat_sticky == 1'b0, "R7", "no clamp yet", 128'(sat_sticky), 128'd0);

        // R4: product clamp, half and word
        a = '0; a[16*2 +: 16] = 16'h8000; b = '0; b[16*5 +: 16] = 16'h8000; c = '0;
        op(mk(1'b0, 5), a, b, c, 1'b0, "R4_half");
        idle(1);
        clear_only();
        a = '0; a[64 +: 32] = 32'h8000_0000; b = '0; b[32*2 +: 32] = 32'h8000_0000;
        c = '0; c[63:0] = 64'd5;
        op(mk(1'b1, 2), a, b, c, 1'b0, "R4_word");
        clear_only();

        // R5: positive and negative accumulate clamp
        a = {8{16'h4000}}; b = {8{16'h4000}}; c = {4{32'h7FFF_0000}};
        op(mk(1'b0, 0), a, b, c, 1'b0, "R5_pos");
        a = {8{16'h8000}}; b = {8{16'h7FFF}}; c = {4{32'h8000_0001}};
        op(mk(1'b0, 7), a, b, c, 1'b0, "R5_neg");
        a = {4{32'h8000_0000}}; b = {4{32'h7FFF_FFFF}}; c = {2{64'h8000_0000_0000_0000}};
        op(mk(1'b1, 3), a, b, c, 1'b0, "R5_neg_word");
        idle(1);

        // R7: clear together with a new clamp keeps flag set
        a = {8{16'h8000}}; b = {8{16'h8000}}; c = '0;
        op(mk(1'b0, 1), a, b, c, 1'b1, "R7_clr_and_set");
        idle(1);
        check(sat_sticky == 1'b1, "R7", "hold", 128'(sat_sticky), 128'd1);
        clear_only();

        // R1: illegal words pass accumulator through, sticky untouched
        a = {8{16'h8000}}; b = {8{16'h8000}}; c = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
        op(mk(1'b0, 0) & ~32'h0080_0000, a, b, c, 1'b0, "R1_size");
        op(mk(1'b0, 0) | 32'h0000_0400, a, b, c, 1'b0, "R1_bit10");
        op(mk(1'b1, 0) ^ 32'h0100_0000, a, b, c, 1'b0, "R1_top");
        op(mk(1'b1, 0) & ~32'h0020_0000, a, b, c, 1'b0, "R1_bit21");
        idle(1);
        check(sat_sticky == 1'b0, "R1", "sticky after illegal", 128'(sat_sticky), 128'd0);

        // R8: odd elements ignored
        a = {8{16'h1234}}; b = {8{16'h0321}}; c = {4{32'h0000_1000}};
        a2 = a;
        for (int k = 0; k < 4; k++) a2[(2*k+1)*16 +: 16] = 16'h8000;
        op(mk(1'b0, 4), a, b, c, 1'b0, "R8_base");
        op(mk(1'b0, 4), a2, b, c, 1'b0, "R8_odd");
        a2 = a;
        a2[32 +: 32] = 32'hDEAD_BEEF; a2[96 +: 32] = 32'h8000_0000;
        op(mk(1'b1, 1), a2, b, c, 1'b0, "R8_odd_word");
        idle(2);
        check(out_valid == 1'b0, "R6", "drain", 128'(out_valid), 128'd0);
        check(q_res.size() == 0, "R6", "queue empty", 128'(q_res.size()), 128'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule